// File: doc/BRIEF.md
# FP16 Vector Multiply-Extended by Broadcast Element

This block is a half-precision floating-point multiplier for a SIMD datapath. It takes one FP16 element from a second source vector, picked by a 3-bit index. It multiplies every active lane of a first source vector by that element and produces a destination vector. A width-select bit chooses between two forms. The narrow form covers four lanes in the low 64 bits. The wide form covers eight lanes across all 128 bits.

The multiply follows IEEE 754 binary16 rules, with two exceptions:

- **Infinity times zero.** This pairing, in either operand order, yields 2.0 with the XOR of the operand signs, rather than an invalid NaN.
- **NaN priority.** An input NaN is passed on quieted, and a NaN in the first source wins over one in the selected element.

Other details of the arithmetic:

- Rounding is round-to-nearest-even.
- Subnormal operands and results are kept exactly, with no flushing to zero.
- Four exception flags are reported for each operation. They are the OR over the active lanes and are not carried over from one operation to the next.

Results and flags are registered by default, so the block is a one-cycle pipeline stage. A parameter turns it into pure combinational logic instead.

Top module: `hvec_mulx_elem`

## Requirements
- R1: Each active lane result equals lane i of `src_a_i` (bits 16i+15:16i) times the selected element, rounded to nearest-even into FP16. Subnormal inputs and results are computed exactly, without flushing.
- R2: The multiplier is lane `idx_i` of `src_b_i`. All eight lanes of `src_b_i` can be addressed in both forms, and the same element is applied to every active lane.
- R3: With `wide_i` = 0, only lanes 0 to 3 are active. Bits 127:64 of `res_o` are zero, and the inactive lanes raise no flag even when they hold signaling NaNs.
- R4: An infinity multiplied by a zero, in either order, gives 2.0. The result is 0x4000 when the operand signs match and 0xC000 when they differ, and no flag is raised.
- R5: A NaN in `src_a_i` is returned with fraction bit 9 set and takes priority. Otherwise a NaN in the selected element is returned, quieted the same way. Invalid is raised exactly when an active operand is a signaling NaN (exponent all ones, fraction nonzero, bit 9 clear).
- R6: A finite product whose rounded magnitude exceeds 65504 becomes an infinity with the product's sign (0x7C00 or 0xFC00). It raises overflow and inexact.
- R7: Inexact is raised whenever the rounded result differs from the exact product. Underflow is raised when the exact product is nonzero and below 2^-14 in magnitude, and the result is also inexact.
- R8: `flags_o` bit 3 is invalid, bit 2 overflow, bit 1 underflow and bit 0 inexact. Each bit is the OR over the active lanes of one operation only, so an operation raising no condition reports 0 even after one that did.
- R9: With the default registered form, results and flags appear after the first rising clock edge following the inputs. An active-low reset clears `res_o` and `flags_o` to zero.
- R10: An infinity times a finite nonzero value gives an infinity with the XOR sign. A zero times a finite value gives a zero with the XOR sign. Neither case raises a flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a_i | input | 128 | First source vector, eight FP16 lanes |
| src_b_i | input | 128 | Second source vector, holds the broadcast element |
| idx_i | input | 3 | Lane index of the broadcast element in `src_b_i` |
| wide_i | input | 1 | 1: eight lanes (128-bit form), 0: four lanes (64-bit form) |
| res_o | output | 128 | Destination vector |
| flags_o | output | 4 | {invalid, overflow, underflow, inexact} for the operation |

## Verification
Every result lane and the flag bits belong to the inputs applied one rising edge earlier. The bench drives inputs on the falling edge and records the expected vector in a queue. On the next falling edge it compares the outputs against the front of that queue, so each sample falls half a period after the edge that loaded the register. A design that answered a cycle early or late would therefore miscompare against every vector. The reset state is sampled while reset is still held and the inputs carry nonzero data.

// File: rtl/hmx_pkg.sv
package hmx_pkg;

   localparam int FP_W    = 16;
   localparam int EXP_W   = 5;
   localparam int MAN_W   = 10;
   localparam int BIAS    = 15;
   localparam int SIG_W   = MAN_W + 1;
   localparam int PROD_W  = 2 * SIG_W;
   localparam int ESUM_W  = EXP_W + 2;
   localparam int FLG_W   = 4;

   localparam int FLG_INV = 3;
   localparam int FLG_OVF = 2;
   localparam int FLG_UNF = 1;
   localparam int FLG_INX = 0;

   typedef struct packed {
      logic             sign;
      logic [EXP_W-1:0] exp;
      logic [MAN_W-1:0] man;
   } fp16_t;

   typedef enum logic [2:0] {
      CLS_ZERO,
      CLS_SUB,
      CLS_NORM,
      CLS_INF,
      CLS_QNAN,
      CLS_SNAN
   } fp_cls_e;

   function automatic fp_cls_e fp_classify(input fp16_t v);
      if (v.exp == '1) begin
         if (v.man == '0)        return CLS_INF;
         else if (v.man[MAN_W-1]) return CLS_QNAN;
         else                    return CLS_SNAN;
      end
      if (v.exp == '0) return (v.man == '0) ? CLS_ZERO : CLS_SUB;
      return CLS_NORM;
   endfunction

   function automatic logic fp_is_nan(input fp_cls_e c);
      return (c == CLS_QNAN) || (c == CLS_SNAN);
   endfunction

   function automatic fp16_t fp_quiet(input fp16_t v);
      fp16_t q;
      q = v;
      q.man[MAN_W-1] = 1'b1;
      return q;
   endfunction

endpackage

// File: rtl/hmx_elem_pick.sv
module hmx_elem_pick
   import hmx_pkg::*;
#(
   parameter int LANES = 8
)(
   input  logic [LANES*FP_W-1:0]     vec_i,
   input  logic [$clog2(LANES)-1:0]  idx_i,
   output logic [FP_W-1:0]           elem_o
);

   localparam int IDX_W = $clog2(LANES);

   logic [FP_W-1:0] lane_arr [LANES];

   for (genvar l = 0; l < LANES; l++) begin : g_split
      assign lane_arr[l] = vec_i[l*FP_W +: FP_W];
   end

   always_comb begin
      elem_o = lane_arr[0];
      for (int l = 1; l < LANES; l++) begin
         if (idx_i == IDX_W'(l)) elem_o = lane_arr[l];
      end
   end

endmodule

// File: rtl/hmx_norm_round.sv
module hmx_norm_round
   import hmx_pkg::*;
(
   input  logic              sign_i,
   input  logic [PROD_W-1:0] prod_i,
   input  logic [ESUM_W-1:0] esum_i,
   output logic [FP_W-1:0]   res_o,
   output logic              ovf_o,
   output logic              unf_o,
   output logic              inx_o
);

   localparam int LZ_W   = $clog2(PROD_W);
   localparam int PAD_W  = SIG_W + 1;
   localparam int SHX_W  = PROD_W + PAD_W;
   localparam int MAX_SH = SHX_W - 1;
   localparam int EMAX   = (1 << EXP_W) - 1;

   logic [LZ_W-1:0]   msb_pos;
   logic [LZ_W-1:0]   lz;
   logic [PROD_W-1:0] pn;
   int                be;
   int                sh;
   int                e_out;
   logic [SHX_W-1:0]  xw;
   logic [SHX_W-1:0]  yw;
   logic [SHX_W-1:0]  one_v;
   logic [SHX_W-1:0]  mask;
   logic              lost;
   logic [SIG_W-1:0]  keep;
   logic              guard;
   logic              sticky;
   logic              rnd;
   logic [SIG_W:0]    mr;
   logic              tiny;

   // leading one of the raw product
   always_comb begin
      msb_pos = '0;
      for (int i = 0; i < PROD_W; i++) begin
         if (prod_i[i]) msb_pos = LZ_W'(i);
      end
      lz = LZ_W'(PROD_W - 1) - msb_pos;
   end

   // normalise, then denormalise by the amount the exponent lies below 1
   always_comb begin
      pn    = prod_i << lz;
      be    = int'(esum_i) - (BIAS - 1) - int'(lz);
      tiny  = (be < 1);
      if (!tiny)               sh = 0;
      else if (1 - be > MAX_SH) sh = MAX_SH;
      else                     sh = 1 - be;
      xw    = {pn, {PAD_W{1'b0}}};
      yw    = xw >> sh;
      one_v = {{(SHX_W-1){1'b0}}, 1'b1};
      mask  = (one_v << sh) - one_v;
      lost  = |(xw & mask);
      keep  = yw[SHX_W-1 -: SIG_W];
      guard = yw[SHX_W-1-SIG_W];
      sticky = (|yw[SHX_W-2-SIG_W:0]) | lost;
      rnd   = guard & (sticky | keep[0]);
      mr    = {1'b0, keep} + {{SIG_W{1'b0}}, rnd};
      e_out = be + int'(mr[SIG_W]);
   end

   // pack
   always_comb begin
      ovf_o = 1'b0;
      unf_o = 1'b0;
      inx_o = guard | sticky;
      if (tiny) begin
         res_o = {sign_i, {(EXP_W-1){1'b0}}, mr[MAN_W], mr[MAN_W-1:0]};
         unf_o = guard | sticky;
      end else if (e_out >= EMAX) begin
         res_o = {sign_i, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
         ovf_o = 1'b1;
         inx_o = 1'b1;
      end else begin
         res_o = {sign_i, EXP_W'(e_out), mr[SIG_W] ? {MAN_W{1'b0}} : mr[MAN_W-1:0]};
      end
   end

endmodule

// File: rtl/hmx_lane.sv
module hmx_lane
   import hmx_pkg::*;
(
   input  logic [FP_W-1:0]  a_i,
   input  logic [FP_W-1:0]  b_i,
   output logic [FP_W-1:0]  res_o,
   output logic [FLG_W-1:0] flg_o
);

   fp16_t             a, b;
   fp_cls_e           ca, cb;
   logic              sr;
   logic [SIG_W-1:0]  sig_a, sig_b;
   logic [EXP_W-1:0]  eff_a, eff_b;
   logic [PROD_W-1:0] prod;
   logic [ESUM_W-1:0] esum;
   logic [FP_W-1:0]   fin_res;
   logic              fin_ovf, fin_unf, fin_inx;
   logic              a_inf, b_inf, a_zero, b_zero;

   assign a  = fp16_t'(a_i);
   assign b  = fp16_t'(b_i);
   assign ca = fp_classify(a);
   assign cb = fp_classify(b);
   assign sr = a.sign ^ b.sign;

   assign a_inf  = (ca == CLS_INF);
   assign b_inf  = (cb == CLS_INF);
   assign a_zero = (ca == CLS_ZERO);
   assign b_zero = (cb == CLS_ZERO);

   // subnormals use exponent 1 with no hidden bit
   assign sig_a = {a.exp != '0, a.man};
   assign sig_b = {b.exp != '0, b.man};
   assign eff_a = (a.exp == '0) ? EXP_W'(1) : a.exp;
   assign eff_b = (b.exp == '0) ? EXP_W'(1) : b.exp;
   assign prod  = PROD_W'(sig_a) * PROD_W'(sig_b);
   assign esum  = ESUM_W'(eff_a) + ESUM_W'(eff_b);

   hmx_norm_round u_nr (
      .sign_i (sr),
      .prod_i (prod),
      .esum_i (esum),
      .res_o  (fin_res),
      .ovf_o  (fin_ovf),
      .unf_o  (fin_unf),
      .inx_o  (fin_inx)
   );

   always_comb begin
      flg_o = '0;
      if (fp_is_nan(ca)) begin
         res_o          = fp_quiet(a);
         flg_o[FLG_INV] = (ca == CLS_SNAN) || (cb == CLS_SNAN);
      end else if (fp_is_nan(cb)) begin
         res_o          = fp_quiet(b);
         flg_o[FLG_INV] = (cb == CLS_SNAN);
      end else if ((a_inf && b_zero) || (a_zero && b_inf)) begin
         res_o = {sr, 1'b1, {(FP_W-2){1'b0}}};
      end else if (a_inf || b_inf) begin
         res_o = {sr, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
      end else if (a_zero || b_zero) begin
         res_o = {sr, {(FP_W-1){1'b0}}};
      end else begin
         res_o          = fin_res;
         flg_o[FLG_OVF] = fin_ovf;
         flg_o[FLG_UNF] = fin_unf;
         flg_o[FLG_INX] = fin_inx;
      end
   end

endmodule

// File: rtl/hmx_flag_merge.sv
module hmx_flag_merge
   import hmx_pkg::*;
#(
   parameter int LANES = 8
)(
   input  logic [LANES*FLG_W-1:0] flags_i,
   input  logic [LANES-1:0]       act_i,
   output logic [FLG_W-1:0]       flags_o
);

   always_comb begin
      flags_o = '0;
      for (int l = 0; l < LANES; l++) begin
         if (act_i[l]) flags_o = flags_o | flags_i[l*FLG_W +: FLG_W];
      end
   end

endmodule

// File: rtl/hvec_mulx_elem.sv
module hvec_mulx_elem
   import hmx_pkg::*;
#(
   parameter int LANES   = 8,
   parameter bit REG_OUT = 1'b1
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [LANES*FP_W-1:0]     src_a_i,
   input  logic [LANES*FP_W-1:0]     src_b_i,
   input  logic [$clog2(LANES)-1:0]  idx_i,
   input  logic                      wide_i,
   output logic [LANES*FP_W-1:0]     res_o,
   output logic [FLG_W-1:0]          flags_o
);

   localparam int VEC_W  = LANES * FP_W;
   localparam int HALF   = LANES / 2;
   localparam int HALF_W = HALF * FP_W;

   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("hvec_mulx_elem: LANES must be a power of two, at least 2");
   end

   logic [FP_W-1:0]        elem_b;
   logic [VEC_W-1:0]       lane_res;
   logic [LANES*FLG_W-1:0] lane_flg;
   logic [LANES-1:0]       act;
   logic [VEC_W-1:0]       res_nxt;
   logic [FLG_W-1:0]       flg_nxt;

   hmx_elem_pick #(.LANES(LANES)) u_pick (
      .vec_i  (src_b_i),
      .idx_i  (idx_i),
      .elem_o (elem_b)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      hmx_lane u_lane (
         .a_i   (src_a_i[l*FP_W +: FP_W]),
         .b_i   (elem_b),
         .res_o (lane_res[l*FP_W +: FP_W]),
         .flg_o (lane_flg[l*FLG_W +: FLG_W])
      );
      if (l < HALF) begin : g_low
         assign act[l] = 1'b1;
      end else begin : g_high
         assign act[l] = wide_i;
      end
      assign res_nxt[l*FP_W +: FP_W] = act[l] ? lane_res[l*FP_W +: FP_W] : '0;
   end

   hmx_flag_merge #(.LANES(LANES)) u_merge (
      .flags_i (lane_flg),
      .act_i   (act),
      .flags_o (flg_nxt)
   );

   // checker-side views of the inputs, derived apart from the lanes
   logic            snan_any;
   logic            infz0;
   logic [FP_W-1:0] two_val0;
   logic            one0;
   logic [FP_W-1:0] pick_ref;

   always_comb begin
      pick_ref = src_b_i[idx_i*FP_W +: FP_W];
      snan_any = (fp_classify(fp16_t'(pick_ref)) == CLS_SNAN);
      for (int l = 0; l < LANES; l++) begin
         if ((l < HALF || wide_i) &&
             fp_classify(fp16_t'(src_a_i[l*FP_W +: FP_W])) == CLS_SNAN)
            snan_any = 1'b1;
      end
      infz0 = (fp_classify(fp16_t'(src_a_i[FP_W-1:0])) == CLS_INF  &&
               fp_classify(fp16_t'(pick_ref)) == CLS_ZERO) ||
              (fp_classify(fp16_t'(src_a_i[FP_W-1:0])) == CLS_ZERO &&
               fp_classify(fp16_t'(pick_ref)) == CLS_INF);
      two_val0 = {src_a_i[FP_W-1] ^ pick_ref[FP_W-1], 15'h4000};
      one0     = (src_a_i[FP_W-1:0] == 16'h3C00) &&
                 (fp_classify(fp16_t'(pick_ref)) != CLS_SNAN);
   end

   if (REG_OUT) begin : g_reg
      logic [VEC_W-1:0] res_q;
      logic [FLG_W-1:0] flg_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_q <= '0;
            flg_q <= '0;
         end else begin
            res_q <= res_nxt;
            flg_q <= flg_nxt;
         end
      end

      assign res_o   = res_q;
      assign flags_o = flg_q;

      // R3
      narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !wide_i |=> (res_o[VEC_W-1:HALF_W] == '0));

      // R5
      invalid_needs_snan_chk: assert property (@(posedge clk) disable iff (!rst_n)
         flags_o[FLG_INV] |-> $past(snan_any));

      // R4
      inf_zero_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
         infz0 |=> (res_o[FP_W-1:0] == $past(two_val0)));

      // R2
      unit_passes_elem_chk: assert property (@(posedge clk) disable iff (!rst_n)
         one0 |=> (res_o[FP_W-1:0] == $past(pick_ref)));
   end else begin : g_comb
      assign res_o   = res_nxt;
      assign flags_o = flg_nxt;
   end

   // R6
   ovf_implies_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags_o[FLG_OVF] |-> flags_o[FLG_INX]);

   // R7
   unf_implies_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags_o[FLG_UNF] |-> flags_o[FLG_INX]);

endmodule

// File: tb/test_hvec_mulx_elem.sv
module test_hvec_mulx_elem;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [127:0] src_a = '0;
   logic [127:0] src_b = '0;
   logic [2:0]   idx = '0;
   logic         wide = 1'b1;
   logic [127:0] res;
   logic [3:0]   flags;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [127:0] res;
      logic [3:0]   flg;
      string        tag;
   } exp_t;

   exp_t pend[$];

   always #10 clk = ~clk;

   hvec_mulx_elem i_hvec_mulx_elem (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_a_i (src_a),
      .src_b_i (src_b),
      .idx_i   (idx),
      .wide_i  (wide),
      .res_o   (res),
      .flags_o (flags)
   );

   function automatic real pow2(input int n);
      real r = 1.0;
      if (n >= 0) repeat (n) r = r * 2.0;
      else        repeat (-n) r = r / 2.0;
      return r;
   endfunction

   function automatic real mag16(input logic [15:0] v);
      int ex = int'(v[14:10]);
      int mn = int'(v[9:0]);
      if (ex == 0) return real'(mn) * pow2(-24);
      return real'(mn + 1024) * pow2(ex - 25);
   endfunction

   function automatic void ref_lane(input logic [15:0] a, input logic [15:0] b,
                                    output logic [15:0] r, output logic [3:0] f);
      logic sr = a[15] ^ b[15];
      logic an = (a[14:10] == 5'h1f) && (a[9:0] != 0);
      logic bn = (b[14:10] == 5'h1f) && (b[9:0] != 0);
      logic ai = (a[14:10] == 5'h1f) && (a[9:0] == 0);
      logic bi = (b[14:10] == 5'h1f) && (b[9:0] == 0);
      logic az = (a[14:0] == 0);
      logic bz = (b[14:0] == 0);
      real  p, m, q, fr;
      int   e, qi;
      logic inx, tiny;
      f = '0;
      if (an || bn) begin
         f[3] = (an && !a[9]) || (bn && !b[9]);
         r = an ? (a | 16'h0200) : (b | 16'h0200);
      end else if ((ai && bz) || (az && bi)) begin
         r = {sr, 15'h4000};
      end else if (ai || bi) begin
         r = {sr, 15'h7c00};
      end else if (az || bz) begin
         r = {sr, 15'h0000};
      end else begin
         p = mag16(a) * mag16(b);
         m = p; e = 0;
         while (m >= 2.0) begin m = m / 2.0; e++; end
         while (m < 1.0)  begin m = m * 2.0; e--; end
         tiny = (e < -14);
         q  = tiny ? p * pow2(24) : p * pow2(10 - e);
         qi = $rtoi(q);
         fr = q - real'(qi);
         inx = (fr != 0.0);
         if (fr > 0.5 || (fr == 0.5 && (qi % 2) == 1)) qi++;
         if (tiny) begin
            r = {sr, 15'(qi)};
            f[1] = inx;
            f[0] = inx;
         end else begin
            if (qi == 2048) begin qi = 1024; e++; end
            if (e > 15) begin
               r = {sr, 15'h7c00};
               f[2] = 1'b1;
               f[0] = 1'b1;
            end else begin
               r = {sr, 5'(e + 15), 10'(qi - 1024)};
               f[0] = inx;
            end
         end
      end
   endfunction

   function automatic logic [127:0] put(input logic [127:0] v, input int k, input logic [15:0] x);
      logic [127:0] o = v;
      o[k*16 +: 16] = x;
      return o;
   endfunction

   task automatic check_out();
      exp_t e;
      if (pend.size() == 0) return;
      e = pend.pop_front();
      for (int l = 0; l < 8; l++) begin
         checks++;
         if (res[l*16 +: 16] !== e.res[l*16 +: 16]) begin
            errors++;
            $display("FAIL %s lane %0d result %h expected %h", e.tag, l,
                     res[l*16 +: 16], e.res[l*16 +: 16]);
         end
      end
      checks++;
      if (flags !== e.flg) begin
         errors++;
         $display("FAIL %s flags %b expected %b", e.tag, flags, e.flg);
      end
   endtask

   task automatic step(input logic [127:0] a, input logic [127:0] b,
                       input logic [2:0] k, input logic w, input string tag);
      exp_t e;
      logic [15:0] r;
      logic [3:0]  f;
      @(negedge clk);
      check_out();
      src_a = a; src_b = b; idx = k; wide = w;
      e.res = '0; e.flg = '0; e.tag = tag;
      for (int l = 0; l < 8; l++) begin
         if (w || l < 4) begin
            ref_lane(a[l*16 +: 16], b[int'(k)*16 +: 16], r, f);
            e.res[l*16 +: 16] = r;
            e.flg = e.flg | f;
         end
      end
      pend.push_back(e);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [127:0] a, b;

      // R9: reset holds outputs at zero despite live inputs
      src_a = {8{16'h3C00}}; src_b = {8{16'h4000}};
      repeat (3) @(negedge clk);
      checks++;
      if (res !== '0) begin errors++; $display("FAIL R9 reset result %h expected 0", res); end
      checks++;
      if (flags !== '0) begin errors++; $display("FAIL R9 reset flags %b expected 0000", flags); end
      rst_n = 1'b1;

      // R1: ordinary products, including rounding
      a = {16'h4200, 16'hC000, 16'h3555, 16'h0001, 16'h7000, 16'h3C01, 16'hBC00, 16'h3C00};
      b = put({8{16'h5140}}, 2, 16'h3E00);
      step(a, b, 3'd2, 1'b1, "R1");
      step(a, put(b, 5, 16'h3555), 3'd5, 1'b1, "R1");

      // R2: sweep every index, distinct element values
      b = '0;
      for (int j = 0; j < 8; j++) b = put(b, j, 16'(16'h3C00 + j * 16'h0080));
      a = {16'h4000, 16'h3800, 16'hC200, 16'h3C00, 16'h4400, 16'h3A00, 16'hBC00, 16'h3C00};
      for (int k = 0; k < 8; k++) step(a, b, 3'(k), 1'b1, "R2");
      step(a, b, 3'd7, 1'b0, "R2");
      step(a, b, 3'd6, 1'b0, "R2");

      // R3: narrow form, upper lanes hold signaling NaNs and must be silent
      a = {16'h7D00, 16'h7C01, 16'hFD55, 16'h7D00, 16'h4000, 16'h3800, 16'hC000, 16'h3C00};
      step(a, {8{16'h4000}}, 3'd0, 1'b0, "R3");
      step(a, {8{16'h4000}}, 3'd0, 1'b1, "R3");

      // R4: infinity times zero in both orders and both zero signs
      a = {16'h7C00, 16'hFC00, 16'h7C00, 16'hFC00, 16'h7C00, 16'h3C00, 16'h7C00, 16'hFC00};
      step(a, put({8{16'h3C00}}, 1, 16'h0000), 3'd1, 1'b1, "R4");
      step(a, put({8{16'h3C00}}, 4, 16'h8000), 3'd4, 1'b1, "R4");
      a = {16'h0000, 16'h8000, 16'h0000, 16'h8000, 16'h0000, 16'h8000, 16'h0000, 16'h8000};
      step(a, put('0, 0, 16'h7C00), 3'd0, 1'b1, "R4");
      step(a, put('0, 3, 16'hFC00), 3'd3, 1'b1, "R4");

      // R5: NaN propagation and invalid
      a = {16'h3C00, 16'h3C00, 16'h3C00, 16'h3C00, 16'hFD00, 16'h7C05, 16'h7E12, 16'h4000};
      step(a, {8{16'h4000}}, 3'd0, 1'b1, "R5");
      a = {16'h3C00, 16'h3C00, 16'h3C00, 16'h3C00, 16'h3C00, 16'h3C00, 16'h7E12, 16'h4000};
      step(a, put({8{16'h4000}}, 6, 16'h7D33), 3'd6, 1'b1, "R5");
      step(a, put({8{16'h4000}}, 2, 16'hFE01), 3'd2, 1'b1, "R5");
      step({8{16'h3C00}}, {8{16'h4000}}, 3'd0, 1'b1, "R8");

      // R6: overflow to signed infinity, and just inside the range
      a = {16'h3C00, 16'h3C00, 16'h3C00, 16'h3C00, 16'h3C00, 16'h3C00, 16'hFBFF, 16'h7BFF};
      step(a, {8{16'h4000}}, 3'd0, 1'b1, "R6");
      step(a, {8{16'h3C01}}, 3'd0, 1'b1, "R6");
      step(a, {8{16'h3C00}}, 3'd0, 1'b1, "R6");
      step({8{16'h3C00}}, {8{16'h3C00}}, 3'd0, 1'b1, "R8");

      // R7: subnormal results and operands
      step({8{16'h0400}}, {8{16'h3800}}, 3'd0, 1'b1, "R7");
      step({8{16'h0001}}, {8{16'h3800}}, 3'd0, 1'b1, "R7");
      step({8{16'h0003}}, {8{16'h3800}}, 3'd0, 1'b1, "R7");
      step({8{16'h03FF}}, {8{16'h3C01}}, 3'd0, 1'b1, "R7");
      step({8{16'h0200}}, {8{16'h7800}}, 3'd0, 1'b1, "R7");
      step({8{16'h0001}}, {8{16'h0001}}, 3'd0, 1'b1, "R7");
      step({8{16'h2E66}}, {8{16'h0155}}, 3'd0, 1'b1, "R7");

      // R10: infinity and zero with finite operands
      a = {16'h7C00, 16'hFC00, 16'h0000, 16'h8000, 16'h7C00, 16'h0000, 16'hFC00, 16'h8000};
      step(a, {8{16'hC200}}, 3'd0, 1'b1, "R10");
      step(a, {8{16'h0001}}, 3'd0, 1'b1, "R10");

      // R1: broad random mix in both forms
      for (int n = 0; n < 400; n++) begin
         a = {$urandom, $urandom, $urandom, $urandom};
         b = {$urandom, $urandom, $urandom, $urandom};
         step(a, b, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), "R1");
      end

      @(negedge clk);
      check_out();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule